// File: doc/BRIEF.md
# Buffered Trigger Readout Sequencer

This block turns event triggers into a sequence of converter requests. Each trigger arrives with a channel hit bitmap: bit i set means channel i is above threshold. When nothing is being converted and nothing is waiting, a trigger starts conversion in the next cycle. A trigger that arrives while an event is being converted goes into a four-entry event queue. The queued events are then converted one after another, oldest first. New events can therefore be accepted while the converter works on an earlier one, which absorbs triggers that arrive closer together than one conversion series takes.

Only flagged channels are converted, in ascending index order. The series stops after the highest flagged channel instead of walking every channel. Each converted word leaves the block tagged with its channel number, and the last word of an event carries an end-of-event marker. An event with an empty bitmap produces a lone end-of-event marker. The bitmap of each event is presented on a side output when its conversion begins, for the downstream data controller. When a trigger finds the queue full while another event is in conversion, the trigger is dropped and an overflow pulse is raised.

Top module: `trig_readout_seq`

## Requirements
- R1: Up to four triggered events wait in the queue behind the event being converted, and they are converted in trigger order.
- R2: A trigger sampled while `busy_o` is low makes `map_valid_o` and `adc_start_o` high in the next cycle, with `adc_chan_o` equal to the lowest set bit index of the bitmap.
- R3: A trigger sampled while `busy_o` is high and fewer than four events wait is accepted, and its event is converted later.
- R4: Only the channels whose bitmap bit is 1 are converted, in ascending index order. Each output word carries its channel index on `out_chan_o` and the `adc_data_i` value sampled with `adc_done_i`.
- R5: The number of `adc_start_o` pulses for an event equals the number of set bits. `out_eoe_o` is high together with `out_valid_o` on the word of the highest set channel.
- R6: `map_valid_o` pulses for one cycle when an event's conversion begins, with that event's bitmap on `map_o`, in trigger order.
- R7: A trigger sampled while four events wait and a fifth is in conversion is dropped. `ovf_o` is high for exactly the next cycle, and the dropped event never appears on `map_o` or the data outputs.
- R8: An all-zero bitmap produces no `adc_start_o` and a single cycle with `out_eoe_o` high and `out_valid_o` low, two cycles after the trigger when idle.
- R9: `busy_o` is high while an event is in conversion or queued. It is low from the cycle in which the final end-of-event marker appears.
- R10: A synchronous active-low reset clears every output to 0 and discards both the active event and the queued events.
- R11: `adc_chan_o` holds its value from an `adc_start_o` pulse until the matching `adc_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Event trigger, one cycle per event |
| hitmap_i | input | NCH | Channel hit bitmap sampled with `trig_i`; bit i is channel i |
| adc_done_i | input | 1 | Converter finished the requested channel |
| adc_data_i | input | DW | Converted value, valid with `adc_done_i` |
| adc_start_o | output | 1 | One-cycle conversion request |
| adc_chan_o | output | CW | Channel to convert |
| out_valid_o | output | 1 | Converted word valid |
| out_chan_o | output | CW | Channel tag of the output word |
| out_data_o | output | DW | Converted value |
| out_eoe_o | output | 1 | End-of-event marker |
| busy_o | output | 1 | Event in conversion or queued |
| ovf_o | output | 1 | One-cycle pulse when a trigger is dropped |
| map_valid_o | output | 1 | One-cycle pulse when an event's conversion begins |
| map_o | output | NCH | Bitmap of the event that began |

## Verification
A corrupted queue pointer or count shows at the ports as bitmaps on `map_o` that are out of order, repeated or lost. It can also show as an overflow pulse at the wrong trigger. Either fault appears at the latest when the affected event begins, one conversion series later. A wrong remaining-channel mask shows in the very next `adc_start_o`: a channel that is not ascending, a channel that is not flagged, or an end-of-event marker on the wrong word. The bench therefore logs every word, every forwarded bitmap and every overflow pulse and compares them with lists built from the trigger table.

// File: rtl/rdo_pkg.sv
// Shared types for the readout sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package rdo_pkg;
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_ISSUE = 2'd1,
        SC_WAIT  = 2'd2,
        SC_EOE   = 2'd3
    } scan_st_t;
endpackage

// File: rtl/rdo_evq.sv
// Event queue: first-in first-out store of pending hit bitmaps.
// Assumes: push is never asserted when full unless pop is asserted in the same cycle.
module rdo_evq #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [NW-1:0] count;

    // Next pointer value with wrap at DEPTH.
    function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_i) wr_ptr <= inc_ptr(wr_ptr);
            if (pop_i)  rd_ptr <= inc_ptr(rd_ptr);
            if (push_i && !pop_i)      count <= count + 1'b1;
            else if (pop_i && !push_i) count <= count - 1'b1;
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push_i) mem[wr_ptr] <= din_i;
    end

    assign dout_o  = mem[rd_ptr];
    assign empty_o = (count == '0);
    assign full_o  = (count == NW'(DEPTH));
endmodule

// File: rtl/rdo_low_enc.sv
// Lowest-set-bit encoder: returns the index of the lowest 1 in vec_i.
// Assumes: returns 0 when vec_i is all zero; callers qualify by that case.
module rdo_low_enc #(
    parameter int NCH = 8,
    parameter int CW  = 3
) (
    input  logic [NCH-1:0] vec_i,
    output logic [CW-1:0]  idx_o
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = CW'(i);
        end
    end
endmodule

// File: rtl/rdo_scan.sv
// Conversion scanner: walks the set bits of one event bitmap in ascending
// order, requests one conversion per set bit and emits tagged words.
// Assumes: adc_done_i only arrives after an adc_start_o request.
module rdo_scan
    import rdo_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 3,
    parameter int DW  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch_i,
    input  logic [NCH-1:0] map_i,
    output logic           idle_o,
    output logic           adc_start_o,
    output logic [CW-1:0]  adc_chan_o,
    input  logic           adc_done_i,
    input  logic [DW-1:0]  adc_data_i,
    output logic           map_valid_o,
    output logic [NCH-1:0] map_o,
    output logic           out_valid_o,
    output logic [CW-1:0]  out_chan_o,
    output logic [DW-1:0]  out_data_o,
    output logic           out_eoe_o
);
    scan_st_t       state;
    logic [NCH-1:0] rem;
    logic [NCH-1:0] rem_next;
    logic [CW-1:0]  cur_chan;

    rdo_low_enc #(.NCH(NCH), .CW(CW)) u_enc (
        .vec_i (rem),
        .idx_o (cur_chan)
    );

    // Remaining mask with the lowest flagged channel removed.
    assign rem_next = rem & (rem - 1'b1);

    // Scanner state, remaining mask and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SC_IDLE;
            rem         <= '0;
            map_o       <= '0;
            map_valid_o <= 1'b0;
            out_valid_o <= 1'b0;
            out_eoe_o   <= 1'b0;
            out_chan_o  <= '0;
            out_data_o  <= '0;
        end else begin
            map_valid_o <= 1'b0;
            out_valid_o <= 1'b0;
            out_eoe_o   <= 1'b0;
            case (state)
                SC_IDLE: begin
                    if (launch_i) begin
                        rem         <= map_i;
                        map_o       <= map_i;
                        map_valid_o <= 1'b1;
                        state       <= (map_i == '0) ? SC_EOE : SC_ISSUE;
                    end
                end
                SC_ISSUE: state <= SC_WAIT;
                SC_WAIT: begin
                    if (adc_done_i) begin
                        out_valid_o <= 1'b1;
                        out_chan_o  <= cur_chan;
                        out_data_o  <= adc_data_i;
                        rem         <= rem_next;
                        if (rem_next == '0) begin
                            out_eoe_o <= 1'b1;
                            state     <= SC_IDLE;
                        end else begin
                            state <= SC_ISSUE;
                        end
                    end
                end
                SC_EOE: begin
                    out_eoe_o <= 1'b1;
                    state     <= SC_IDLE;
                end
                default: state <= SC_IDLE;
            endcase
        end
    end

    assign idle_o      = (state == SC_IDLE);
    assign adc_start_o = (state == SC_ISSUE);
    assign adc_chan_o  = cur_chan;
endmodule

// File: rtl/trig_readout_seq.sv
// Buffered trigger readout sequencer: accepts triggers with hit bitmaps,
// starts conversion at once when idle, otherwise queues the event, and
// drops a trigger with an overflow pulse when the queue is full.
// Assumes: trig_i is a one-cycle pulse per event.
module trig_readout_seq #(
    parameter int NCH   = 8,
    parameter int DW    = 10,
    parameter int DEPTH = 4,
    localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trig_i,
    input  logic [NCH-1:0] hitmap_i,
    input  logic           adc_done_i,
    input  logic [DW-1:0]  adc_data_i,
    output logic           adc_start_o,
    output logic [CW-1:0]  adc_chan_o,
    output logic           out_valid_o,
    output logic [CW-1:0]  out_chan_o,
    output logic [DW-1:0]  out_data_o,
    output logic           out_eoe_o,
    output logic           busy_o,
    output logic           ovf_o,
    output logic           map_valid_o,
    output logic [NCH-1:0] map_o
);
    logic           scan_idle;
    logic           q_empty, q_full;
    logic [NCH-1:0] q_head;
    logic           launch, pop, push_req, push;
    logic [NCH-1:0] launch_map;

    // Launch the oldest queued event, or the new trigger when nothing waits.
    assign pop        = scan_idle && !q_empty;
    assign launch     = scan_idle && (!q_empty || trig_i);
    assign launch_map = q_empty ? hitmap_i : q_head;
    assign push_req   = trig_i && !(scan_idle && q_empty);
    assign push       = push_req && (!q_full || pop);

    rdo_evq #(.DEPTH(DEPTH), .W(NCH)) u_evq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .din_i   (hitmap_i),
        .dout_o  (q_head),
        .empty_o (q_empty),
        .full_o  (q_full)
    );

    rdo_scan #(.NCH(NCH), .CW(CW), .DW(DW)) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch),
        .map_i       (launch_map),
        .idle_o      (scan_idle),
        .adc_start_o (adc_start_o),
        .adc_chan_o  (adc_chan_o),
        .adc_done_i  (adc_done_i),
        .adc_data_i  (adc_data_i),
        .map_valid_o (map_valid_o),
        .map_o       (map_o),
        .out_valid_o (out_valid_o),
        .out_chan_o  (out_chan_o),
        .out_data_o  (out_data_o),
        .out_eoe_o   (out_eoe_o)
    );

    // Overflow pulse for a trigger that found no room.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_o <= 1'b0;
        else        ovf_o <= push_req && !push;
    end

    assign busy_o = !scan_idle || !q_empty;
endmodule

// File: rtl/rdo_chk.sv
// Port-level checker for the readout sequencer, bound to the top module.
// Assumes: trig_i is held low during reset.
module rdo_chk #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          trig_i,
    input logic          adc_start_o,
    input logic [CW-1:0] adc_chan_o,
    input logic          out_valid_o,
    input logic [CW-1:0] out_chan_o,
    input logic          out_eoe_o,
    input logic          busy_o,
    input logic          ovf_o,
    input logic          map_valid_o
);
    AST_IDLE_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(trig_i) && !$past(busy_o) |-> map_valid_o); // R2

    AST_ASCENDING_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_eoe_o |-> adc_start_o && (adc_chan_o > out_chan_o)); // R4

    AST_OVF_NEEDS_BUSY_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(rst_n) && $past(trig_i) && $past(busy_o)); // R7

    AST_OVF_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && !trig_i |=> !ovf_o); // R7

    AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o || map_valid_o |-> busy_o); // R9

    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start_o |=> $stable(adc_chan_o) && !adc_start_o); // R11
endmodule

bind trig_readout_seq rdo_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_i      (trig_i),
    .adc_start_o (adc_start_o),
    .adc_chan_o  (adc_chan_o),
    .out_valid_o (out_valid_o),
    .out_chan_o  (out_chan_o),
    .out_eoe_o   (out_eoe_o),
    .busy_o      (busy_o),
    .ovf_o       (ovf_o),
    .map_valid_o (map_valid_o)
);

// File: tb/trig_readout_seq_tb.sv
// Self-checking bench for the readout sequencer.
module trig_readout_seq_tb;
    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int CW  = 3;
    localparam int LAT = 8;
    localparam int NV  = 5;
    // Vector table: {bitmap, expected conversion count}.
    localparam logic [11:0] VEC [NV] = '{
        {8'h05, 4'd2}, {8'h00, 4'd0}, {8'h80, 4'd1}, {8'hFF, 4'd8}, {8'h48, 4'd2}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           trig = 1'b0;
    logic [NCH-1:0] hitmap = '0;
    logic           adc_done = 1'b0;
    logic [DW-1:0]  adc_data = '0;
    logic           adc_start, out_valid, out_eoe, busy, ovf, map_valid;
    logic [CW-1:0]  adc_chan, out_chan;
    logic [DW-1:0]  out_data;
    logic [NCH-1:0] map;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    trig_readout_seq #(.NCH(NCH), .DW(DW), .DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .hitmap_i(hitmap),
        .adc_done_i(adc_done), .adc_data_i(adc_data),
        .adc_start_o(adc_start), .adc_chan_o(adc_chan),
        .out_valid_o(out_valid), .out_chan_o(out_chan), .out_data_o(out_data),
        .out_eoe_o(out_eoe), .busy_o(busy), .ovf_o(ovf),
        .map_valid_o(map_valid), .map_o(map)
    );

    // Converter model: answers each request after LAT cycles.
    int adc_cnt = 0;
    int conv = 0;
    always @(negedge clk) begin
        adc_done = 1'b0;
        if (!rst_n) adc_cnt = 0;
        else if (adc_cnt > 0) begin
            adc_cnt--;
            if (adc_cnt == 0) begin
                adc_done = 1'b1;
                adc_data = DW'(10'h100 + conv);
                conv++;
            end
        end else if (adc_start) adc_cnt = LAT;
    end

    // Output monitor logs.
    int            nlog = 0, nmap = 0, nstart = 0, novf = 0;
    logic          lg_val [64];
    logic          lg_eoe [64];
    logic [CW-1:0] lg_chan [64];
    logic [DW-1:0] lg_data [64];
    logic [NCH-1:0] mp_log [16];
    always @(negedge clk) begin
        if (out_valid || out_eoe) begin
            if (nlog < 64) begin
                lg_val[nlog] = out_valid; lg_eoe[nlog] = out_eoe;
                lg_chan[nlog] = out_chan; lg_data[nlog] = out_data;
            end
            nlog++;
        end
        if (map_valid) begin
            if (nmap < 16) mp_log[nmap] = map;
            nmap++;
        end
        if (adc_start) nstart++;
        if (ovf) novf++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(posedge clk);
        nlog = 0; nmap = 0; nstart = 0; novf = 0;
    endtask

    task automatic fire(input logic [NCH-1:0] m);
        @(negedge clk);
        trig = 1'b1; hitmap = m;
        @(negedge clk);
        trig = 1'b0; hitmap = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy && !out_eoe) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base, idx, j, hi;
        logic [NCH-1:0] m;
        // R10: reset state.
        repeat (3) @(negedge clk);
        chk(!adc_start && !out_valid && !out_eoe && !busy && !ovf && !map_valid,
            "R10 reset outputs", int'(busy), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: five triggers two cycles apart (R1, R3, R4, R5, R6).
        clear_logs();
        base = conv;
        for (int v = 0; v < NV; v++) begin
            fire(VEC[v][11:4]);
            if (v > 0) chk(busy, "R3 busy while queueing", int'(busy), 1);
        end
        wait_idle();
        chk(novf == 0, "R7 no overflow at four queued", novf, 0);
        chk(nmap == NV, "R6 forwarded bitmap count", nmap, NV);
        for (int v = 0; v < NV; v++)
            chk(mp_log[v] == VEC[v][11:4], "R1 R6 trigger order", int'(mp_log[v]), int'(VEC[v][11:4]));
        idx = 0; j = 0;
        for (int v = 0; v < NV; v++) begin
            m = VEC[v][11:4];
            chk($countones(m) == int'(VEC[v][3:0]), "R5 table popcount", $countones(m), int'(VEC[v][3:0]));
            if (m == '0) begin
                chk(!lg_val[idx] && lg_eoe[idx], "R8 empty event marker", int'(lg_val[idx]), 0);
                idx++;
            end else begin
                hi = 0;
                for (int b = 0; b < NCH; b++) if (m[b]) hi = b;
                for (int b = 0; b < NCH; b++) begin
                    if (m[b]) begin
                        chk(lg_val[idx] && lg_chan[idx] == CW'(b), "R4 channel tag", int'(lg_chan[idx]), b);
                        chk(lg_data[idx] == DW'(10'h100 + base + j), "R4 data word", int'(lg_data[idx]), 10'h100 + base + j);
                        chk(lg_eoe[idx] == (b == hi), "R5 end marker position", int'(lg_eoe[idx]), int'(b == hi));
                        idx++; j++;
                    end
                end
            end
        end
        chk(nlog == idx, "R4 word count", nlog, idx);
        chk(nstart == 13, "R5 conversions total", nstart, 13);

        // R2: immediate start from idle.
        clear_logs();
        @(negedge clk);
        trig = 1'b1; hitmap = 8'h28;
        @(negedge clk);
        trig = 1'b0; hitmap = '0;
        chk(adc_start && map_valid, "R2 start next cycle", int'(adc_start), 1);
        chk(adc_chan == 3'd3, "R2 first channel", int'(adc_chan), 3);
        chk(map == 8'h28, "R6 map on start", int'(map), 8'h28);
        wait_idle();
        chk(nstart == 2, "R5 stops after highest channel", nstart, 2);
        chk(nlog == 2 && lg_eoe[1] && lg_chan[1] == 3'd5, "R5 marker on channel 5", int'(lg_chan[1]), 5);

        // R8, R9: empty bitmap while idle.
        clear_logs();
        @(negedge clk);
        trig = 1'b1; hitmap = 8'h00;
        @(negedge clk);
        trig = 1'b0;
        chk(map_valid && !adc_start, "R8 no conversion request", int'(adc_start), 0);
        @(negedge clk);
        chk(out_eoe && !out_valid, "R8 marker two cycles after trigger", int'(out_eoe), 1);
        chk(!busy, "R9 busy low with final marker", int'(busy), 0);
        wait_idle();
        chk(nstart == 0 && nlog == 1, "R8 single marker only", nlog, 1);

        // R7: six back-to-back triggers, the sixth is dropped.
        clear_logs();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            trig = 1'b1; hitmap = NCH'(1 << k);
        end
        @(negedge clk);
        trig = 1'b0; hitmap = '0;
        chk(busy, "R9 busy with queue full", int'(busy), 1);
        wait_idle();
        chk(novf == 1, "R7 one overflow pulse", novf, 1);
        chk(nmap == 5, "R7 dropped event not forwarded", nmap, 5);
        for (int k = 0; k < 5; k++)
            chk(mp_log[k] == NCH'(1 << k), "R1 drain order", int'(mp_log[k]), 1 << k);
        chk(nlog == 5, "R7 dropped event not converted", nlog, 5);

        // R10: reset in the middle of a series discards everything.
        fire(8'hFF);
        fire(8'h0F);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !adc_start && !out_valid && !map_valid, "R10 mid-run reset", int'(busy), 0);
        rst_n = 1'b1;
        clear_logs();
        repeat (30) @(negedge clk);
        chk(nlog == 0 && nstart == 0 && !busy, "R10 queue discarded", nlog + nstart, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule